// File: doc/BRIEF.md
# Paired-Register I2C Target

This block is a target (slave) on a two-wire I2C bus. It holds eight 8-bit registers arranged as four pairs: two input ports, two output ports, two polarity masks and two direction (configuration) bytes. The output, polarity and configuration registers are exposed to the core as parallel signals. The two input ports come from core pins and can be read over the bus. Both bus lines are sampled by a fast system clock. The block drives SDA only as an open-drain pull-down enable.

A master selects a register by writing a command byte right after the address. Further bytes of the same transfer, in either direction, alternate between that register and its partner in the pair, and do not advance through the map. The register pointer lives on across a repeated START. A read that follows a write of the command therefore starts at the chosen register. A read that follows an earlier read continues at the partner of the last byte read.

Top module: `pairptr_i2c_target`

## Requirements
- R1: After reset, SDA is released (sdaOe = 0), the output and configuration registers read 0xFF, the polarity registers read 0x00, and the pointer is 0.
- R2: The 7-bit target address is the fixed upper six bits 010000 followed by addrSel as the LSB. On a match, the target pulls SDA low in the ninth clock of the address byte. On a mismatch, it leaves SDA released for every clock until the next START.
- R3: The target acknowledges the command byte in every case. Values 0..7 load the pointer: 0/1 are input ports 0/1, 2/3 are outputs 0/1, 4/5 are polarity 0/1 and 6/7 are configuration 0/1. Values above 7 leave the pointer unchanged.
- R4: In a write transfer, each data byte after the command byte is acknowledged and stored at the pointer. The pointer then flips its LSB, so bytes alternate between a register and its partner.
- R5: Data written to pointer 0 or 1 (the input ports) is discarded. No register changes and the pointer still toggles.
- R6: After a START with R/W = 1, the target shifts out the byte at the pointer MSB first. Each further byte acknowledged by the master comes from the other register of the pair.
- R7: When the master does not acknowledge a read byte, the target releases SDA and keeps it released until the next START or STOP.
- R8: The pointer is not reset by a START or STOP. A read after a repeated START resumes at the partner of the last register read.
- R9: An input-port byte reads as its pin value XOR its polarity register. The value is captured when the byte's shift-out begins and stays fixed for that byte.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen after synchronisation. The SDA enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Selects the LSB of the target address |
| portIn0 | input | 8 | Pin values of input port 0 |
| portIn1 | input | 8 | Pin values of input port 1 |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| outPort0 | output | 8 | Output register 0 |
| outPort1 | output | 8 | Output register 1 |
| polPort0 | output | 8 | Polarity mask 0 |
| polPort1 | output | 8 | Polarity mask 1 |
| cfgPort0 | output | 8 | Configuration register 0 |
| cfgPort1 | output | 8 | Configuration register 1 |

## Verification
The pointer is tested with several patterns:
- An odd start register is read three bytes long, which separates toggling from incrementing.
- A second read follows a repeated START after a NACK, which shows that the pointer is kept rather than reloaded.
- A write with an out-of-range command shows that the data lands at the old pointer.
- Writes to the input ports check that they are dropped.

An input pin is changed in the middle of a byte, which tells capture-at-byte-start apart from live sampling. The polarity XOR is then checked on both ports with distinct masks. Wrong-address traffic and a change of addrSel confirm that only the selected address is answered.

// File: rtl/pairptr_pkg.sv
package pairptr_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int FIRST_RW = 2;  // indices below this are input ports
  localparam int POL_BASE = 4;  // first polarity mask index

  typedef struct packed {
    logic              wrStb;
    logic [PTR_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
    logic [PTR_W-1:0]  rdIdx;
  } ctrlStb_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } busState_t;

  function automatic logic [BYTE_W-1:0] resetVal(int idx);
    return (idx >= POL_BASE && idx < POL_BASE + 2) ? '0 : '1;
  endfunction
endpackage

// File: rtl/pairptr_regs.sv
module pairptr_regs
  import pairptr_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  ctrlStb_t                               stb,
  input  logic [BYTE_W-1:0]                      portIn0,
  input  logic [BYTE_W-1:0]                      portIn1,
  output logic [BYTE_W-1:0]                      rdByte,
  output logic [(NUM_REGS-FIRST_RW)*BYTE_W-1:0]  rwFlat
);
  logic [BYTE_W-1:0] storeQ [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REGS; k++) storeQ[k] <= resetVal(k);
    end else begin
      for (int k = FIRST_RW; k < NUM_REGS; k++)
        if (stb.wrStb && stb.wrIdx == PTR_W'(k)) storeQ[k] <= stb.wrData;
    end
  end

  // Read mux: input ports pass through their polarity mask.
  always_comb begin
    if (stb.rdIdx < PTR_W'(FIRST_RW))
      rdByte = stb.rdIdx[0] ? (portIn1 ^ storeQ[POL_BASE + 1])
                            : (portIn0 ^ storeQ[POL_BASE]);
    else
      rdByte = storeQ[stb.rdIdx];
  end

  for (genvar g = FIRST_RW; g < NUM_REGS; g++) begin : gRw
    assign rwFlat[(g-FIRST_RW)*BYTE_W +: BYTE_W] = storeQ[g];

    AST_STORE_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(storeQ[g]) |-> $past(stb.wrStb && stb.wrIdx == PTR_W'(g)));  // R4
  end
endmodule

// File: rtl/pairptr_ctrl.sv
module pairptr_ctrl
  import pairptr_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] rdByte,
  output ctrlStb_t          stb,
  output logic              sdaOe
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t         state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [PTR_W-1:0]  ptr;
  logic              rwBit, masterAck;
  logic              wrStbQ;
  logic [PTR_W-1:0]  wrIdxQ;
  logic [BYTE_W-1:0] wrDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1; sdaPipe <= '1; sclQ <= 1'b1; sdaQ <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; shiftReg <= '0; ptr <= '0;
      rwBit <= 1'b0; masterAck <= 1'b0; sdaOe <= 1'b0;
      wrStbQ <= 1'b0; wrIdxQ <= '0; wrDataQ <= '0;
    end else begin
      wrStbQ <= 1'b0;
      if (startDet) begin
        state <= ST_ADDR; bitCnt <= '0; sdaOe <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE; sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (sclRise && bitCnt < LAST_BIT) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shiftReg[BYTE_W-1:1] == {ADDR_HI, addrSel}) begin
                  state <= ST_ADDR_ACK; sdaOe <= 1'b1; rwBit <= shiftReg[0];
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_CMD) begin
                if (shiftReg[BYTE_W-1:PTR_W] == '0) ptr <= shiftReg[PTR_W-1:0];
                state <= ST_CMD_ACK; sdaOe <= 1'b1;
              end else begin
                wrStbQ  <= 1'b1; wrIdxQ <= ptr; wrDataQ <= shiftReg;
                ptr     <= {ptr[PTR_W-1:1], ~ptr[0]};
                state   <= ST_WR_ACK; sdaOe <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rwBit) begin
                shiftReg <= rdByte; sdaOe <= ~rdByte[BYTE_W-1]; state <= ST_RD;
              end else begin
                sdaOe <= 1'b0; state <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WR_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0; state <= ST_WR; bitCnt <= '0;
            end
          end
          ST_RD: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaOe  <= 1'b0; state <= ST_RD_ACK; bitCnt <= '0;
                ptr    <= {ptr[PTR_W-1:1], ~ptr[0]};
              end else begin
                shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
                sdaOe    <= ~shiftReg[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                shiftReg <= rdByte; sdaOe <= ~rdByte[BYTE_W-1];
                state <= ST_RD; bitCnt <= '0;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb.wrStb  = wrStbQ;
    stb.wrIdx  = wrIdxQ;
    stb.wrData = wrDataQ;
    stb.rdIdx  = ptr;
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);  // R10
  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK || state == ST_CMD_ACK || state == ST_WR_ACK) |-> sdaOe);  // R2
  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT || state == ST_IDLE) |-> !sdaOe);  // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> ($past(state) == ST_CMD) ||
                      (ptr == {$past(ptr[PTR_W-1:1]), ~$past(ptr[0])}));  // R4
endmodule

// File: rtl/pairptr_i2c_target.sv
module pairptr_i2c_target
  import pairptr_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b010000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] portIn0,
  input  logic [7:0] portIn1,
  output logic       sdaOe,
  output logic [7:0] outPort0,
  output logic [7:0] outPort1,
  output logic [7:0] polPort0,
  output logic [7:0] polPort1,
  output logic [7:0] cfgPort0,
  output logic [7:0] cfgPort1
);
  ctrlStb_t                              stb;
  logic [BYTE_W-1:0]                     rdByte;
  logic [(NUM_REGS-FIRST_RW)*BYTE_W-1:0] rwFlat;

  pairptr_ctrl #(.ADDR_HI(ADDR_HI), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdByte(rdByte), .stb(stb), .sdaOe(sdaOe)
  );

  pairptr_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .portIn0(portIn0), .portIn1(portIn1),
    .rdByte(rdByte), .rwFlat(rwFlat)
  );

  assign {cfgPort1, cfgPort0, polPort1, polPort0, outPort1, outPort0} = rwFlat;
endmodule

// File: tb/pairptr_i2c_target_bench.sv
module pairptr_i2c_target_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 20;      // system clocks per quarter SCL period
  localparam int WDOG  = 190000;

  typedef struct { string req; logic [7:0] val; } expItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b0;
  logic [7:0] portIn0 = 8'h55, portIn1 = 8'h81;
  logic sdaOe, sdaBus;
  logic [7:0] outPort0, outPort1, polPort0, polPort1, cfgPort0, cfgPort1;

  int nChecks = 0, nFail = 0;
  expItem_t expQ[$];
  logic [7:0] rdAct;
  event rdEvt;
  bit midChange = 0;
  logic [7:0] midVal = 8'h00;
  logic ackBit;
  logic [7:0] dummy;

  always #(CLK_P/2) clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  pairptr_i2c_target u_pairptr_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrSel(addrSel),
    .portIn0(portIn0), .portIn1(portIn1), .sdaOe(sdaOe),
    .outPort0(outPort0), .outPort1(outPort1), .polPort0(polPort0),
    .polPort1(polPort1), .cfgPort0(cfgPort0), .cfgPort1(cfgPort1)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); ack = sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(input bit giveAck);
    logic [7:0] b;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (i == 3 && midChange) portIn1 = midVal;
      waitQ(); sclM = 1'b1; waitQ(); b[i] = sdaBus; waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = giveAck ? 1'b0 : 1'b1;
    waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ();
    sdaM = 1'b1;
    rdAct = b;
    -> rdEvt;
    waitQ();
  endtask

  task automatic expectRead(input string req, input logic [7:0] v);
    expItem_t it;
    it.req = req; it.val = v;
    expQ.push_back(it);
  endtask

  function automatic logic [7:0] devAddr(input logic sel, input logic rw);
    return {6'b010000, sel, rw};
  endfunction

  // Scoreboard monitor
  initial begin
    forever begin
      expItem_t it;
      @(rdEvt);
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R6: actual %h expected none (queue empty)", rdAct);
      end else begin
        it = expQ.pop_front();
        check(it.req, rdAct, it.val);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic setCmd(input logic [7:0] cmd);
    busStart();
    writeByte(devAddr(addrSel, 1'b0), ackBit); check("R2 addr ack", {7'd0, ackBit}, 8'h00);
    writeByte(cmd, ackBit);                    check("R3 cmd ack",  {7'd0, ackBit}, 8'h00);
  endtask

  task automatic readStart();
    busStart();
    writeByte(devAddr(addrSel, 1'b1), ackBit); check("R10 rstart addr ack", {7'd0, ackBit}, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 sdaOe", {7'd0, sdaOe}, 8'h00);
    check("R1 out0", outPort0, 8'hFF); check("R1 out1", outPort1, 8'hFF);
    check("R1 pol0", polPort0, 8'h00); check("R1 pol1", polPort1, 8'h00);
    check("R1 cfg0", cfgPort0, 8'hFF); check("R1 cfg1", cfgPort1, 8'hFF);

    // R4 paired write into outputs
    setCmd(8'h02);
    writeByte(8'hA5, ackBit); check("R4 data ack", {7'd0, ackBit}, 8'h00);
    writeByte(8'h3C, ackBit); check("R4 data ack", {7'd0, ackBit}, 8'h00);
    busStop();
    check("R4 out0", outPort0, 8'hA5); check("R4 out1", outPort1, 8'h3C);

    // R6 toggled reads, R7 nack release, R8 pointer kept over rstart
    setCmd(8'h03);
    readStart();
    expectRead("R6 first byte", 8'h3C); readByte(1'b1);
    expectRead("R6 partner byte", 8'hA5); readByte(1'b1);
    expectRead("R6 toggled back", 8'h3C); readByte(1'b0);
    check("R7 released after nack", {7'd0, sdaOe}, 8'h00);
    writeByte(8'hFF, ackBit); check("R7 no drive after nack", {7'd0, ackBit}, 8'h01);
    readStart();
    expectRead("R8 resume at partner", 8'hA5); readByte(1'b0);
    busStop();

    // R9 polarity applied to inputs
    setCmd(8'h04);
    writeByte(8'h0F, ackBit); writeByte(8'hF0, ackBit);
    busStop();
    check("R4 pol0", polPort0, 8'h0F); check("R4 pol1", polPort1, 8'hF0);
    setCmd(8'h00); readStart();
    expectRead("R9 in0 xor pol", 8'h5A); readByte(1'b1);
    expectRead("R9 in1 xor pol", 8'h71); readByte(1'b0);
    busStop();

    // R9 capture at byte start
    setCmd(8'h01); readStart();
    midChange = 1; midVal = 8'h7E;
    expectRead("R9 captured value", 8'h71); readByte(1'b0);
    midChange = 0;
    busStop();
    setCmd(8'h01); readStart();
    expectRead("R9 new pin value", 8'h8E); readByte(1'b0);
    busStop();

    // R5 writes to input ports discarded
    setCmd(8'h00);
    writeByte(8'h12, ackBit); check("R5 ack", {7'd0, ackBit}, 8'h00);
    writeByte(8'h34, ackBit); check("R5 ack", {7'd0, ackBit}, 8'h00);
    busStop();
    check("R5 pol0 kept", polPort0, 8'h0F); check("R5 pol1 kept", polPort1, 8'hF0);
    check("R5 out0 kept", outPort0, 8'hA5); check("R5 out1 kept", outPort1, 8'h3C);
    check("R5 cfg0 kept", cfgPort0, 8'hFF); check("R5 cfg1 kept", cfgPort1, 8'hFF);
    setCmd(8'h00); readStart();
    expectRead("R5 in0 unchanged", 8'h5A); readByte(1'b1);
    expectRead("R5 in1 unchanged", 8'h8E); readByte(1'b0);
    busStop();

    // R3 out-of-range command keeps pointer
    setCmd(8'h06); writeByte(8'h11, ackBit); busStop();
    check("R4 cfg0", cfgPort0, 8'h11);
    setCmd(8'h0A); writeByte(8'h22, ackBit); busStop();
    check("R3 data to old ptr", cfgPort1, 8'h22);
    check("R3 cfg0 untouched", cfgPort0, 8'h11);

    // R2 wrong address ignored
    busStart();
    writeByte(devAddr(1'b1, 1'b0), ackBit); check("R2 mismatch nack", {7'd0, ackBit}, 8'h01);
    writeByte(8'h06, ackBit); check("R2 no ack after mismatch", {7'd0, ackBit}, 8'h01);
    writeByte(8'h99, ackBit); check("R2 no ack after mismatch", {7'd0, ackBit}, 8'h01);
    busStop();
    check("R2 cfg0 untouched", cfgPort0, 8'h11);

    // R2 address select pin
    addrSel = 1'b1;
    repeat (5) @(negedge clk);
    setCmd(8'h06); writeByte(8'h44, ackBit); busStop();
    check("R2 sel=1 write", cfgPort0, 8'h44);
    busStart();
    writeByte(devAddr(1'b0, 1'b0), ackBit); check("R2 old addr nack", {7'd0, ackBit}, 8'h01);
    busStop();
    check("R10 idle released", {7'd0, sdaOe}, 8'h00);

    waitQ(4);
    if (expQ.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL R6: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end
endmodule